// File: doc/BRIEF.md
# Streaming Two-Dimensional 8x8 DCT for Raster Video

This block takes raster video one line at a time and turns each 8x8 tile of the picture into its 64 two-dimensional DCT coefficients without ever stalling the pixel input. A line-sync pulse starts each line and a frame-sync pulse starts each frame. Each active sample is taken while the pixel-valid input is high. Every run of eight pixels along a line is passed through an eight-point transform. The results are parked in a two-bank buffer, transposed, so that once eight lines (one band) have arrived, each tile's columns can be fetched as single words.

While the next band is arriving and being row-transformed into one bank, the finished band in the other bank is read back through the same eight-point transform to perform the vertical pass. Only one transform datapath exists. The row pass takes it whenever a row vector is pending, and the column pass uses every other cycle. The clock must run at least twice the pixel rate, with a few idle cycles per line. The coefficients of a band leave as a stream with a valid strobe and a marker on the first coefficient of each tile.

Top module: `dct2d_band_engine`

## Requirements
- R1: After reset `coef_valid` and `coef_first` are low, and no coefficient is emitted before eight complete lines of active pixels have been received.
- R2: A pixel is taken only in a cycle with `pix_valid` high and both sync inputs low; a pixel offered in the same cycle as either sync pulse is ignored.
- R3: Each emitted coefficient equals the orthonormal 8x8 DCT-II of its tile, Z(u,v) = sum over r,c of x(r,c)·a(u,r)·a(v,c) with a(0,n)=sqrt(1/8) and a(k,n)=0.5·cos((2n+1)kπ/16) for k>0, computed from the unsigned pixels, to within ±2.
- R4: Tiles of a band leave left to right. Within a tile the 64 coefficients leave with the horizontal frequency v as the outer index and the vertical frequency u as the inner index, both counting up from 0.
- R5: `coef_first` is high exactly on the first coefficient of each tile (u=0, v=0) and never without `coef_valid`.
- R6: Bands follow each other without gaps. The output of band N runs while band N+1 is received, and every band of eight lines yields exactly LINE_W/8 tiles, provided pixels come no more often than every other clock.
- R7: A frame-sync pulse discards any partly received band. The next band is formed from the first eight complete lines that follow the pulse.
- R8: Pixels offered after the LINE_W-th pixel of a line and before the next line sync are ignored.
- R9: A line sync that arrives before a line is complete abandons that line. The next complete line takes its place in the band.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, at least twice the pixel rate |
| rst_n | input | 1 | Synchronous reset, active low |
| line_sync | input | 1 | One-cycle pulse that starts a new line |
| frame_sync | input | 1 | One-cycle pulse that starts a new frame |
| pix_valid | input | 1 | Qualifies `pix_data` as an active sample |
| pix_data | input | 8 | Unsigned pixel value |
| coef_valid | output | 1 | A coefficient is present on `coef_data` |
| coef_first | output | 1 | Marks the first coefficient of a tile |
| coef_data | output | 16 | Signed coefficient, integer scale |

## Verification
The two functions that contend are the row transform of the band being received and the column transform of the stored band. Both need the single eight-point unit, and in steady state a row vector becomes ready while a column vector is half computed. The bench feeds bands back to back with pixels on every second clock, so the column pass of each band is repeatedly preempted by the row pass of the next. Every output coefficient is then compared, in arrival order, against a real-valued DCT of the pixels the bench itself recorded. A lost, repeated or misplaced column step therefore shows up as a wrong value or a wrong tile marker.

// File: rtl/dct_pkg.sv
`timescale 1ns/1ps
// Shared widths, types and the fixed-point cosine table for the band DCT.
// Assumes pixels narrower than the internal word and a 2^FRAC coefficient scale.
package dct_pkg;
    localparam int PIX_W  = 8;
    localparam int WORD_W = 16;
    localparam int COEF_W = 12;
    localparam int FRAC   = 10;
    localparam int ACC_W  = 32;

    typedef logic signed [WORD_W-1:0] word_t;
    typedef word_t [7:0] vec_t;
    typedef enum logic [1:0] {C_IDLE, C_LOAD, C_RUN} col_state_t;

    // Basis value a(k,n) scaled by 2^FRAC; folds the cosine index into one octant.
    function automatic logic signed [COEF_W-1:0] coef(input logic [2:0] k, input logic [2:0] n);
        int j;
        int m;
        int mag;
        if (k == 3'd0) return COEF_W'(362);
        j = ((2 * int'(n) + 1) * int'(k)) % 32;
        if (j > 16) j = 32 - j;
        m = (j > 8) ? 16 - j : j;
        case (m)
            0: mag = 512;
            1: mag = 502;
            2: mag = 473;
            3: mag = 426;
            4: mag = 362;
            5: mag = 284;
            6: mag = 196;
            7: mag = 100;
            default: mag = 0;
        endcase
        return (j > 8) ? COEF_W'(-mag) : COEF_W'(mag);
    endfunction
endpackage

// File: rtl/dct_line_in.sv
`timescale 1ns/1ps
// Raster front end: qualifies samples with the syncs, gathers eight pixels
// into a row vector and tags it with line-in-band, tile and bank.
// Assumes pixels arrive no more often than every other clock.
module dct_line_in
    import dct_pkg::*;
#(
    parameter int LINE_W = 352
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_sync,
    input  logic                 frame_sync,
    input  logic                 pix_valid,
    input  logic [PIX_W-1:0]     pix_data,
    output logic                 vec_ready,
    output vec_t                 vec,
    output logic [2:0]           vec_row,
    output logic [$clog2(LINE_W/8)-1:0] vec_blk,
    output logic                 vec_bank,
    output logic                 vec_last
);
    localparam int COL_W = $clog2(LINE_W);
    localparam int BLK_W = $clog2(LINE_W/8);

    logic [COL_W-1:0] col;
    logic             full;
    logic [2:0]       line;
    logic             bank;
    logic             take;

    assign take = pix_valid && !line_sync && !frame_sync && !full;

    // Track position in line and band, and assemble the eight-pixel vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col       <= '0;
            full      <= 1'b0;
            line      <= '0;
            bank      <= 1'b0;
            vec_ready <= 1'b0;
            vec       <= '0;
            vec_row   <= '0;
            vec_blk   <= '0;
            vec_bank  <= 1'b0;
            vec_last  <= 1'b0;
        end else begin
            vec_ready <= 1'b0;
            if (frame_sync) begin
                col  <= '0;
                full <= 1'b0;
                line <= '0;
                bank <= 1'b0;
            end else if (line_sync) begin
                col  <= '0;
                full <= 1'b0;
            end else if (take) begin
                vec[col[2:0]] <= word_t'({{(WORD_W-PIX_W){1'b0}}, pix_data});
                if (col[2:0] == 3'd7) begin
                    vec_ready <= 1'b1;
                    vec_row   <= line;
                    vec_blk   <= BLK_W'(col >> 3);
                    vec_bank  <= bank;
                    vec_last  <= (line == 3'd7) && (col == COL_W'(LINE_W-1));
                end
                if (col == COL_W'(LINE_W-1)) begin
                    col  <= '0;
                    full <= 1'b1;
                    line <= line + 3'd1;
                    if (line == 3'd7) bank <= ~bank;
                end else begin
                    col <= col + 1'b1;
                end
            end
        end
    end

    // A sample coincident with a sync never completes a vector.
    p_sync_blocks_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (line_sync || frame_sync) |=> !vec_ready);
    // Input rate assumption behind the shared-unit schedule.
    p_pixel_rate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> !pix_valid);
endmodule

// File: rtl/dct_dot8.sv
`timescale 1ns/1ps
// Shared eight-point transform unit: one output coefficient per clock,
// the dot product of an input vector with basis row k, rounded and registered.
module dct_dot8
    import dct_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  vec_t       vec_in,
    input  logic [2:0] k,
    output word_t      res
);
    logic signed [ACC_W-1:0] acc;
    logic signed [ACC_W-1:0] rounded;

    // Multiply-accumulate across the eight lanes.
    always_comb begin
        acc = '0;
        for (int n = 0; n < 8; n++) begin
            acc = acc + ACC_W'($signed(vec_in[n])) * ACC_W'(coef(k, 3'(n)));
        end
        rounded = (acc + ACC_W'(1 << (FRAC-1))) >>> FRAC;
    end

    // Register the rounded result.
    always_ff @(posedge clk) begin
        if (!rst_n) res <= '0;
        else        res <= word_t'(rounded);
    end
endmodule

// File: rtl/dct_band_buf.sv
`timescale 1ns/1ps
// Two-bank transposed band store. Each word row holds one frequency of one
// tile for all eight lines, so a column vector is read in one access.
module dct_band_buf
    import dct_pkg::*;
#(
    parameter int LINE_W = 352
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [$clog2(2*LINE_W)-1:0]  waddr,
    input  logic [2:0]                   wlane,
    input  word_t                        wdata,
    input  logic [$clog2(2*LINE_W)-1:0]  raddr,
    output vec_t                         rdata
);
    localparam int ROWS = 2 * LINE_W;

    vec_t mem [ROWS];

    // Write one row result into its lane.
    always_ff @(posedge clk) begin
        if (we) mem[waddr][wlane] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dct2d_band_engine.sv
`timescale 1ns/1ps
// Band-streaming 8x8 2D DCT. The row pass of the incoming band and the column
// pass of the stored band share one transform unit; the row pass has priority.
// Assumes LINE_W is a multiple of 8 and at least 16, pixels at most every
// other clock, some line blanking, and frame sync only once a band has drained.
module dct2d_band_engine
    import dct_pkg::*;
#(
    parameter int LINE_W = 352
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_sync,
    input  logic              frame_sync,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_data,
    output logic              coef_valid,
    output logic              coef_first,
    output logic [WORD_W-1:0] coef_data
);
    localparam int BLKS  = LINE_W / 8;
    localparam int BLK_W = $clog2(BLKS);
    localparam int AW    = $clog2(2 * LINE_W);

    function automatic logic [AW-1:0] row_addr(input logic bnk, input logic [BLK_W-1:0] blk,
                                               input logic [2:0] k);
        return AW'((int'(bnk) * BLKS + int'(blk)) * 8 + int'(k));
    endfunction

    logic             vec_ready, vec_bank, vec_last;
    vec_t             vec;
    logic [2:0]       vec_row;
    logic [BLK_W-1:0] vec_blk;

    dct_line_in #(.LINE_W(LINE_W)) u_line_in (
        .clk(clk), .rst_n(rst_n), .line_sync(line_sync), .frame_sync(frame_sync),
        .pix_valid(pix_valid), .pix_data(pix_data), .vec_ready(vec_ready), .vec(vec),
        .vec_row(vec_row), .vec_blk(vec_blk), .vec_bank(vec_bank), .vec_last(vec_last)
    );

    // Row-pass state.
    logic             row_busy, row_bank, row_last;
    logic [2:0]       row_k, row_r;
    logic [BLK_W-1:0] row_blk;
    vec_t             row_vec;

    // Column-pass state.
    col_state_t       col_state;
    logic             col_pend, col_pbank, col_bank, col_go, col_end;
    logic [BLK_W-1:0] col_blk, nxt_blk;
    logic [2:0]       col_v, col_u, nxt_v;
    vec_t             col_vec, rd_vec;

    // Stage after the unit.
    logic             s1_row, s1_col, s1_sob, s1_last, s1_bank;
    logic [AW-1:0]    s1_addr;
    logic [2:0]       s1_lane;
    logic             band_full;
    word_t            unit_res;
    vec_t             unit_vec;
    logic [2:0]       unit_k;

    // Capture a ready row vector and walk its eight coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_busy <= 1'b0;
            row_k    <= '0;
            row_r    <= '0;
            row_blk  <= '0;
            row_bank <= 1'b0;
            row_last <= 1'b0;
            row_vec  <= '0;
        end else if (vec_ready) begin
            row_busy <= 1'b1;
            row_k    <= '0;
            row_r    <= vec_row;
            row_blk  <= vec_blk;
            row_bank <= vec_bank;
            row_last <= vec_last;
            row_vec  <= vec;
        end else if (row_busy) begin
            row_k <= row_k + 3'd1;
            if (row_k == 3'd7) row_busy <= 1'b0;
        end
    end

    // Arbitration: the column pass fills the cycles the row pass leaves free.
    assign col_go   = (col_state == C_RUN) && !row_busy;
    assign unit_vec = row_busy ? row_vec : col_vec;
    assign unit_k   = row_busy ? row_k : col_u;

    dct_dot8 u_dot8 (
        .clk(clk), .rst_n(rst_n), .vec_in(unit_vec), .k(unit_k), .res(unit_res)
    );

    // Next column vector to fetch and whether the band is finished.
    always_comb begin
        if (col_state == C_LOAD) begin
            nxt_blk = '0;
            nxt_v   = '0;
        end else if (col_v == 3'd7) begin
            nxt_blk = col_blk + 1'b1;
            nxt_v   = '0;
        end else begin
            nxt_blk = col_blk;
            nxt_v   = col_v + 3'd1;
        end
        col_end = (col_blk == BLK_W'(BLKS-1)) && (col_v == 3'd7);
    end

    dct_band_buf #(.LINE_W(LINE_W)) u_buf (
        .clk(clk), .we(s1_row), .waddr(s1_addr), .wlane(s1_lane), .wdata(unit_res),
        .raddr(row_addr(col_bank, nxt_blk, nxt_v)), .rdata(rd_vec)
    );

    // Tag the unit result for a buffer write or for the output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_row  <= 1'b0;
            s1_col  <= 1'b0;
            s1_sob  <= 1'b0;
            s1_last <= 1'b0;
            s1_bank <= 1'b0;
            s1_addr <= '0;
            s1_lane <= '0;
        end else begin
            s1_row  <= row_busy;
            s1_col  <= col_go;
            s1_sob  <= col_go && (col_u == 3'd0) && (col_v == 3'd0);
            s1_last <= row_busy && row_last && (row_k == 3'd7);
            s1_bank <= row_bank;
            s1_addr <= row_addr(row_bank, row_blk, row_k);
            s1_lane <= row_r;
        end
    end

    assign band_full = s1_last;

    // Column pass sequencer: pending band, initial fetch, then u/v/tile walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_state <= C_IDLE;
            col_pend  <= 1'b0;
            col_pbank <= 1'b0;
            col_bank  <= 1'b0;
            col_blk   <= '0;
            col_v     <= '0;
            col_u     <= '0;
            col_vec   <= '0;
        end else begin
            if (band_full) begin
                col_pend  <= 1'b1;
                col_pbank <= s1_bank;
            end else if (col_state == C_IDLE && col_pend) begin
                col_pend <= 1'b0;
            end
            case (col_state)
                C_IDLE: if (col_pend) begin
                    col_state <= C_LOAD;
                    col_bank  <= col_pbank;
                end
                C_LOAD: begin
                    col_vec   <= rd_vec;
                    col_blk   <= '0;
                    col_v     <= '0;
                    col_u     <= '0;
                    col_state <= C_RUN;
                end
                default: if (col_go) begin
                    col_u <= col_u + 3'd1;
                    if (col_u == 3'd7) begin
                        if (col_end) begin
                            col_state <= C_IDLE;
                        end else begin
                            col_vec <= rd_vec;
                            col_blk <= nxt_blk;
                            col_v   <= nxt_v;
                        end
                    end
                end
            endcase
        end
    end

    assign coef_valid = s1_col;
    assign coef_first = s1_sob;
    assign coef_data  = unit_res;

    // A new row vector never arrives while the previous one is in the unit.
    p_row_no_overlap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_ready |-> !row_busy);
    // A band completes only after the previous band's column pass was taken up.
    p_band_no_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        band_full |-> !col_pend);
    // The tile marker rides only on a valid coefficient.
    p_first_has_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        coef_first |-> coef_valid);
    // The column pass never emits while the row pass holds the unit.
    p_row_priority_r6: assert property (@(posedge clk) disable iff (!rst_n)
        row_busy |=> !coef_valid);
endmodule

// File: tb/dct2d_band_engine_bench.sv
`timescale 1ns/1ps
// Self-checking bench: records accepted pixels behaviourally, computes a
// real-valued DCT per completed band and checks every output on every clock.
module dct2d_band_engine_bench;
    localparam int    LW = 16;
    localparam int    NB = LW / 8;
    localparam real   PI = 3.14159265358979;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        hs = 1'b0, vs = 1'b0, pv = 1'b0;
    logic [7:0]  px = '0;
    logic        cv, cf;
    logic signed [15:0] cd;

    dct2d_band_engine #(.LINE_W(LW)) u_dct2d_band_engine (
        .clk(clk), .rst_n(rst_n), .line_sync(hs), .frame_sync(vs), .pix_valid(pv),
        .pix_data(px), .coef_valid(cv), .coef_first(cf), .coef_data(cd)
    );

    int    checks = 0, fails = 0, emitted = 0, base = 0;
    bit    done = 1'b0;
    int    img [8][LW];
    int    mcol = 0, mline = 0;
    bit    mfull = 1'b0;
    string band_tag = "R1";
    real   exp_q [$];
    bit    sob_q [$];
    string tag_q [$];
    real   e_v, d_v;
    bit    s_v;
    string t_v;

    function automatic real basis(int k, int n);
        return (k == 0 ? $sqrt(0.125) : 0.5) * $cos((2*n+1) * k * PI / 16.0);
    endfunction

    // Expected coefficients of a finished band, tile by tile, v outer, u inner.
    task automatic push_band();
        for (int b = 0; b < NB; b++)
            for (int v = 0; v < 8; v++)
                for (int u = 0; u < 8; u++) begin
                    real s = 0.0;
                    for (int r = 0; r < 8; r++)
                        for (int c = 0; c < 8; c++)
                            s += img[r][b*8+c] * basis(u, r) * basis(v, c);
                    exp_q.push_back(s);
                    sob_q.push_back(u == 0 && v == 0);
                    tag_q.push_back(band_tag);
                end
    endtask

    // Drive one cycle and apply the acceptance rules of R2, R7, R8 and R9.
    task automatic cyc(input bit h, input bit v, input bit e, input int p);
        @(negedge clk);
        hs = h; vs = v; pv = e; px = 8'(p);
        if (v) begin
            mcol = 0; mfull = 1'b0; mline = 0;
        end else if (h) begin
            mcol = 0; mfull = 1'b0;
        end else if (e && !mfull) begin
            img[mline][mcol] = p & 255;
            mcol++;
            if (mcol == LW) begin
                mcol = 0; mfull = 1'b1; mline++;
                if (mline == 8) begin
                    push_band();
                    mline = 0;
                end
            end
        end
    endtask

    function automatic int pixval(int mode, int row, int x);
        case (mode)
            0: return 255;
            1: return (x * 15) % 256;
            2: return row * 30 + 10;
            3: return 64 + int'($urandom_range(127));
            4: return ((row + x) % 2) * 255;
            default: return (x * 7 + row * 11) % 256;
        endcase
    endfunction

    // One line: sync with a coincident pixel (ignored), pixels every other clock, blanking.
    task automatic send_line(input int mode, input int row, input int extra, input int short_n);
        int n;
        cyc(1'b1, 1'b0, 1'b1, 77);
        cyc(1'b0, 1'b0, 1'b0, 0);
        n = (short_n > 0) ? short_n : LW + extra;
        for (int x = 0; x < n; x++) begin
            cyc(1'b0, 1'b0, 1'b1, pixval(mode, row, x));
            cyc(1'b0, 1'b0, 1'b0, 0);
        end
        repeat (4) cyc(1'b0, 1'b0, 1'b0, 0);
    endtask

    task automatic send_band(input int mode);
        for (int r = 0; r < 8; r++) send_line(mode, r, 0, 0);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Compare every output coefficient against the reference queue.
    always @(negedge clk) begin
        if (rst_n && cv && !done) begin
            emitted++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 unexpected coefficient", int'(cd), 0);
            end else begin
                e_v = exp_q.pop_front();
                s_v = sob_q.pop_front();
                t_v = tag_q.pop_front();
                d_v = real'(cd) - e_v;
                checks++;
                if (d_v > 2.0 || d_v < -2.0) begin
                    fails++;
                    $display("FAIL %s R3 R4 coefficient: actual %0d expected %f", t_v, cd, e_v);
                end
                check(cf == s_v, {t_v, " R5 tile marker"}, int'(cf), int'(s_v));
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cv == 1'b0 && cf == 1'b0, "R1 reset outputs", int'({cv, cf}), 0);

        cyc(1'b0, 1'b1, 1'b0, 0);
        band_tag = "R1 R2";
        for (int r = 0; r < 7; r++) send_line(0, r, 0, 0);
        repeat (40) cyc(1'b0, 1'b0, 1'b0, 0);
        check(emitted == 0, "R1 no output before eight lines", emitted, 0);
        send_line(0, 7, 0, 0);

        band_tag = "R6";
        send_band(1);
        send_band(2);
        band_tag = "R8 R9";
        for (int r = 0; r < 8; r++) begin
            if (r == 5) send_line(3, r, 0, 11);
            send_line(3, r, (r == 2) ? 4 : 0, 0);
        end
        band_tag = "R6";
        send_band(4);
        repeat (400) cyc(1'b0, 1'b0, 1'b0, 0);
        check(exp_q.size() == 0, "R6 all bands drained", exp_q.size(), 0);
        check(emitted == 5 * NB * 64, "R6 coefficient count", emitted, 5 * NB * 64);

        base = emitted;
        band_tag = "R7";
        for (int r = 0; r < 3; r++) send_line(5, r, 0, 0);
        cyc(1'b0, 1'b1, 1'b0, 0);
        send_band(3);
        repeat (400) cyc(1'b0, 1'b0, 1'b0, 0);
        check(emitted - base == NB * 64, "R7 partial band discarded", emitted - base, NB * 64);
        check(exp_q.size() == 0, "R7 queue drained", exp_q.size(), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule